// File: doc/BRIEF.md
# Synchronous Handshake Strobe Timer

This block produces the outgoing transfer strobe for one side of a parallel peripheral bus. On the target side that strobe is the request; on the initiator side it is the acknowledge. The data path offers one byte at a time on a valid/ready pair. Each accepted byte yields one strobe pulse. The leading and trailing edges of each pulse can be shifted in half-clock steps, which lets the timing be tuned to the cabling.

A configuration byte carries the timing fields. Bits [1:0] hold the rising-edge delay code and bits [3:2] hold the trailing-edge code. Bits [7:4] hold the offset window. A separate fast-clock bit changes how the trailing-edge code is read.

When the window is nonzero, the block runs synchronously. Pulses are issued back to back, and a counter tracks how many are still waiting for their returning strobe. New bytes stall once that count reaches the window. When the window is zero, each pulse stays high until the far side answers, and the next byte waits for the full interlock to complete.

Back-pressure rules on the byte interface:
- A byte is taken on a rising clock edge where `xfer_valid` and `xfer_ready` are both high.
- `xfer_ready` never depends on `xfer_valid`.
- The data path may hold `xfer_valid` high for as long as it needs to.

The returning strobe must already be synchronous to `clk`.

Top module: `sync_strobe_ctrl`

## Requirements
- R1: A synchronous reset drives `out_strobe` low from the following edge on and clears `pending` to zero. Any delayed edge that had been scheduled is dropped. Once the reset is released, `xfer_ready` is high.
- R2: Let the byte be accepted on edge E, with half-clock edges counted from E. Then `out_strobe` rises 2+A half-cycles after E, where A is the code in cfg[1:0] (00..11 give 0..3). The fast-clock bit has no effect on this.
- R3: In synchronous mode, the strobe falls 6+2·HOLD_CYCLES+T half-cycles after E, where T = 2 + (trailing adjustment in half-cycles).
- R4: With the fast-clock bit low, the cfg[3:2] code gives these trailing adjustments: 00 → 0, 01 → −1 (half a cycle early), 10 → +2, 11 → +1.
- R5: With the fast-clock bit high, the cfg[3:2] code gives these trailing adjustments: 00 → 0, 01 → +1, 10 → +2, 11 → +3.
- R6: `pending` changes as follows:
  - It rises by one for each accepted byte.
  - It falls by one on each edge where `ret_strobe` is first seen high.
  - A returning strobe that arrives while `pending` is zero is ignored.
  - If a byte is accepted on the same edge as a returning strobe, `pending` is unchanged.
- R7: In synchronous mode (cfg[7:4] nonzero), `xfer_ready` is low whenever `pending` is greater than or equal to cfg[7:4]. `stall` equals `xfer_valid` and not `xfer_ready`.
- R8: In asynchronous mode (cfg[7:4] = 0):
  - The strobe stays high until `ret_strobe` is sampled high on some edge X.
  - It then falls 2+T half-cycles after X.
  - `xfer_ready` stays low while `ret_strobe` remains high. It returns one edge after `ret_strobe` is seen low, provided the fall sequence has finished.
- R9: The timing codes and the fast-clock bit are captured when a byte is accepted. Changing them during a pulse does not alter that pulse.
- R10: Only one pulse is in flight at a time. `xfer_ready` is low from the accept edge E until the edge 10+2·HOLD_CYCLES half-cycles after E. From that edge on it is high again, unless the window holds it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are used for half-cycle timing |
| rst | input | 1 | Synchronous reset, active high |
| cfg | input | 4+OFS_W | [1:0] rising delay code, [3:2] trailing code, [7:4] offset window |
| fast_mode | input | 1 | Selects the fast-clock reading of the trailing code |
| xfer_valid | input | 1 | Data path offers a byte |
| xfer_ready | output | 1 | Block will take the offered byte on this edge |
| ret_strobe | input | 1 | Returning handshake strobe from the bus, synchronous to clk |
| out_strobe | output | 1 | Outgoing request/acknowledge strobe |
| stall | output | 1 | A byte is offered but cannot be taken |
| pending | output | OFS_W | Bytes sent whose returning strobe has not yet arrived |

## Verification
The bench builds the block with HOLD_CYCLES set to 1, which is its shortest pulse. At that setting, the latest rising edge (code 11) lies only a few half-cycles before the earliest trailing edge (the half-cycle-early code). Ordering or overlap mistakes in the half-cycle taps therefore show up directly as wrong edge positions.

The window is run at 15, so many bytes can be outstanding. It is also run at 2, so the stall is reached after two bytes. Finally it is run at 0, which exercises the interlocked mode.

A monitor records every edge of `out_strobe` at half-cycle resolution and checks it against positions predicted from the codes.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RISE,
    PH_HOLD,
    PH_FALL,
    PH_WAIT
  } phase_e;

  // Edge timing captured for one pulse:
  //   rise_dly - half-cycles added before the leading edge
  //   fall_thr - half index inside the fall phase where the strobe drops
  typedef struct packed {
    logic [1:0] rise_dly;
    logic [2:0] fall_thr;
  } edge_cfg_t;

  // The nominal drop point is half index 2 of the fall phase. The
  // trailing code moves it by -1..+3 halves, depending on the clock mode.
  function automatic logic [2:0] fall_threshold(input logic [1:0] code,
                                                input logic       fast);
    logic [2:0] thr;
    if (fast) begin
      thr = 3'd2 + {1'b0, code};
    end else begin
      unique case (code)
        2'b00:   thr = 3'd2;
        2'b01:   thr = 3'd1;
        2'b10:   thr = 3'd4;
        default: thr = 3'd3;
      endcase
    end
    return thr;
  endfunction

endpackage

// File: rtl/sst_cfg_decode.sv
module sst_cfg_decode
  import sst_pkg::*;
#(
  parameter int OFS_W = 4,
  localparam int CFG_W = 4 + OFS_W
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             fast_mode,
  output edge_cfg_t        timing,
  output logic [OFS_W-1:0] window,
  output logic             async_mode
);

  localparam int RISE_LSB = 0;
  localparam int FALL_LSB = 2;
  localparam int WIN_LSB  = 4;

  always_comb begin
    timing.rise_dly = cfg[RISE_LSB +: 2];
    timing.fall_thr = fall_threshold(cfg[FALL_LSB +: 2], fast_mode);
    window          = cfg[WIN_LSB +: OFS_W];
    async_mode      = (window == '0);
  end

endmodule

// File: rtl/sst_window.sv
module sst_window #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sent,
  input  logic             returned,
  input  logic [CNT_W-1:0] window,
  input  logic             async_mode,
  output logic [CNT_W-1:0] count,
  output logic             room
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dec;

  assign dec  = returned && (count != '0);
  assign room = async_mode ? (count == '0) : (count < window);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case ({sent, dec})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sst_phase_fsm.sv
module sst_phase_fsm
  import sst_pkg::*;
#(
  parameter int HOLD_CYCLES = 2,
  localparam int STEP_MAX = (HOLD_CYCLES > 3) ? HOLD_CYCLES : 3,
  localparam int STEP_W   = $clog2(STEP_MAX + 1),
  localparam int HW       = STEP_W + 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  edge_cfg_t timing_in,
  input  logic      async_in,
  input  logic      ret_level,
  output logic      half_a,
  output logic      half_b,
  output logic      idle
);

  localparam logic [STEP_W-1:0] ONE       = STEP_W'(1);
  localparam logic [STEP_W-1:0] TWO       = STEP_W'(2);
  localparam logic [STEP_W-1:0] HOLD_LAST = STEP_W'(HOLD_CYCLES - 1);

  phase_e            state, state_n;
  logic [STEP_W-1:0] step, step_n;
  edge_cfg_t         lat;
  logic              lat_async;
  logic [HW-1:0]     ha, hb;

  assign ha   = {step, 1'b0};
  assign hb   = {step, 1'b1};
  assign idle = (state == PH_IDLE);

  always_comb begin
    state_n = state;
    step_n  = step;
    half_a  = 1'b0;
    half_b  = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (start) begin
          state_n = PH_RISE;
          step_n  = '0;
        end
      end
      PH_RISE: begin
        half_a = (ha >= HW'(lat.rise_dly));
        half_b = (hb >= HW'(lat.rise_dly));
        if (step == ONE) begin
          state_n = PH_HOLD;
          step_n  = '0;
        end else begin
          step_n = step + ONE;
        end
      end
      PH_HOLD: begin
        half_a = 1'b1;
        half_b = 1'b1;
        if (lat_async) begin
          if (ret_level) begin
            state_n = PH_FALL;
            step_n  = '0;
          end
        end else if (step == HOLD_LAST) begin
          state_n = PH_FALL;
          step_n  = '0;
        end else begin
          step_n = step + ONE;
        end
      end
      PH_FALL: begin
        half_a = (ha < HW'(lat.fall_thr));
        half_b = (hb < HW'(lat.fall_thr));
        if (step == TWO) begin
          state_n = (lat_async && ret_level) ? PH_WAIT : PH_IDLE;
          step_n  = '0;
        end else begin
          step_n = step + ONE;
        end
      end
      PH_WAIT: begin
        if (!ret_level) state_n = PH_IDLE;
      end
      default: begin
        state_n = PH_IDLE;
        step_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      step      <= '0;
      lat       <= '0;
      lat_async <= 1'b0;
    end else begin
      state <= state_n;
      step  <= step_n;
      if (start && idle) begin
        lat       <= timing_in;
        lat_async <= async_in;
      end
    end
  end

endmodule

// File: rtl/sst_ddr_out.sv
module sst_ddr_out (
  input  logic clk,
  input  logic rst,
  input  logic half_a,
  input  logic half_b,
  output logic strobe
);

  logic pos_q, late_q, neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      pos_q  <= half_a;
      late_q <= half_b;
    end
  end

  // Second-half value moves across on the falling edge.
  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= late_q;
  end

  assign strobe = clk ? pos_q : neg_q;

endmodule

// File: rtl/sync_strobe_ctrl.sv
module sync_strobe_ctrl
  import sst_pkg::*;
#(
  parameter int OFS_W       = 4,
  parameter int HOLD_CYCLES = 2,
  localparam int CFG_W      = 4 + OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             fast_mode,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic             ret_strobe,
  output logic             out_strobe,
  output logic             stall,
  output logic [OFS_W-1:0] pending
);

  edge_cfg_t        timing;
  logic [OFS_W-1:0] win;
  logic             async_mode;
  logic             ret_q, ret_rise, accept, room, idle;
  logic             half_a, half_b;

  sst_cfg_decode #(.OFS_W(OFS_W)) u_dec (
    .cfg        (cfg),
    .fast_mode  (fast_mode),
    .timing     (timing),
    .window     (win),
    .async_mode (async_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) ret_q <= 1'b0;
    else     ret_q <= ret_strobe;
  end

  assign ret_rise   = ret_strobe && !ret_q;
  assign xfer_ready = idle && room;
  assign accept     = xfer_valid && xfer_ready;
  assign stall      = xfer_valid && !xfer_ready;

  sst_window #(.CNT_W(OFS_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .sent       (accept),
    .returned   (ret_rise),
    .window     (win),
    .async_mode (async_mode),
    .count      (pending),
    .room       (room)
  );

  sst_phase_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .timing_in (timing),
    .async_in  (async_mode),
    .ret_level (ret_strobe),
    .half_a    (half_a),
    .half_b    (half_b),
    .idle      (idle)
  );

  sst_ddr_out u_out (
    .clk    (clk),
    .rst    (rst),
    .half_a (half_a),
    .half_b (half_b),
    .strobe (out_strobe)
  );

endmodule

// File: rtl/sst_checks.sv
module sst_checks #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic             ret_rise,
  input logic [CNT_W-1:0] pending,
  input logic [CNT_W-1:0] win
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (pending == '0));

  assert_pending_step_R6: assert property (@(posedge clk) disable iff (rst)
    (pending == $past(pending)) || (pending == $past(pending) + ONE) ||
    (pending + ONE == $past(pending)));

  assert_pending_inc_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready && !ret_rise) |=> (pending == $past(pending) + ONE));

  assert_window_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((win != '0) && (pending >= win)) |-> !xfer_ready);

  assert_single_flight_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready) |=> !xfer_ready);

endmodule

bind sync_strobe_ctrl sst_checks #(.CNT_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .ret_rise   (ret_rise),
  .pending    (pending),
  .win        (win)
);

// File: tb/sync_strobe_ctrl_bench.sv
module sync_strobe_ctrl_bench;

  localparam int HOLD = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg = 8'hF0;
  logic       fast = 1'b0;
  logic       valid = 1'b0;
  logic       ret = 1'b0;
  logic       xfer_ready, stall, out_strobe;
  logic [3:0] pending;

  int    checks = 0;
  int    errors = 0;
  int    hidx = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  int    exp_r[$];
  int    exp_f[$];
  string exp_t[$];

  always #2 clk = ~clk;

  sync_strobe_ctrl #(.OFS_W(4), .HOLD_CYCLES(HOLD)) u_sync_strobe_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg),
    .fast_mode  (fast),
    .xfer_valid (valid),
    .xfer_ready (xfer_ready),
    .ret_strobe (ret),
    .out_strobe (out_strobe),
    .stall      (stall),
    .pending    (pending)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int thr(input bit [1:0] c, input bit f);
    if (f) return 2 + int'(c);
    case (c)
      2'd0:    return 2;
      2'd1:    return 1;
      2'd2:    return 4;
      default: return 3;
    endcase
  endfunction

  // Monitor: half-cycle edge index, scoreboard pop on every falling strobe.
  initial begin : monitor
    bit prev;
    int r;
    prev = 1'b0;
    r = 0;
    forever begin
      @(posedge clk or negedge clk);
      hidx++;
      #1;
      if (mon_en && (out_strobe !== prev)) begin
        if (out_strobe === 1'b1) begin
          r = hidx;
        end else if (exp_r.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R2 unexpected pulse actual=%0d expected=none", r);
        end else begin
          int er;
          int ef;
          string t;
          er = exp_r.pop_front();
          ef = exp_f.pop_front();
          t  = exp_t.pop_front();
          check(r == er, {t, " rise half"}, r, er);
          check(hidx == ef, {t, " fall half"}, hidx, ef);
        end
      end
      prev = (out_strobe === 1'b1);
    end
  end

  task automatic lo();
    @(negedge clk);
    #1;
  endtask

  task automatic hi();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input bit [1:0] a, input bit [1:0] d, input bit f,
                      input bit push, input string tag, input bit ret_at_acc,
                      output int e);
    lo();
    cfg[1:0] = a;
    cfg[3:2] = d;
    fast  = f;
    valid = 1'b1;
    while (!xfer_ready) lo();
    if (ret_at_acc) ret = 1'b1;
    @(posedge clk);
    #1;
    e = hidx;
    valid = 1'b0;
    if (push) begin
      exp_r.push_back(e + 2 + int'(a));
      exp_f.push_back(e + 6 + 2 * HOLD + thr(d, f));
      exp_t.push_back(tag);
    end
  endtask

  task automatic ret_pulse();
    lo();
    ret = 1'b1;
    hi();
    lo();
    ret = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int e;
    int x;
    repeat (3) hi();
    check(out_strobe == 1'b0, "R1 strobe in reset", out_strobe, 0);
    check(pending == 4'd0, "R1 pending in reset", pending, 0);
    lo();
    rst = 1'b0;
    hi();
    check(xfer_ready == 1'b1, "R1 ready after reset", xfer_ready, 1);
    mon_en = 1'b1;

    // R2: every rising-delay code, fast mode on
    for (int a = 0; a < 4; a++) begin
      send(2'(a), 2'd0, 1'b1, 1'b1, "R2", 1'b0, e);
      check(pending == 4'd1, "R6 pending after send", pending, 1);
      ret_pulse();
      check(pending == 4'd0, "R6 pending after return", pending, 0);
    end

    // R10: ready stays low for the whole pulse
    send(2'd0, 2'd0, 1'b0, 1'b1, "R3", 1'b0, e);
    hi();
    check(xfer_ready == 1'b0, "R10 ready low after accept", xfer_ready, 0);
    repeat (3 + HOLD) hi();
    check(xfer_ready == 1'b0, "R10 ready low before end", xfer_ready, 0);
    hi();
    check(xfer_ready == 1'b1, "R10 ready back at end", xfer_ready, 1);
    ret_pulse();

    // R4 and R5: trailing codes in both clock modes
    for (int d = 0; d < 4; d++) begin
      send(2'(3 - d), 2'(d), 1'b0, 1'b1, "R4", 1'b0, e);
      ret_pulse();
    end
    for (int d = 0; d < 4; d++) begin
      send(2'(d), 2'(d), 1'b1, 1'b1, "R5", 1'b0, e);
      ret_pulse();
    end

    // R9: configuration changed right after acceptance
    send(2'd0, 2'd2, 1'b0, 1'b1, "R9", 1'b0, e);
    cfg[1:0] = 2'd3;
    cfg[3:2] = 2'd1;
    fast = 1'b1;
    ret_pulse();

    // R6: simultaneous accept and return, then a spurious return
    send(2'd1, 2'd0, 1'b0, 1'b1, "R2", 1'b0, e);
    check(pending == 4'd1, "R6 first accept", pending, 1);
    send(2'd2, 2'd0, 1'b0, 1'b1, "R2", 1'b1, e);
    check(pending == 4'd1, "R6 accept with return", pending, 1);
    lo();
    ret = 1'b0;
    ret_pulse();
    check(pending == 4'd0, "R6 drained", pending, 0);
    ret_pulse();
    check(pending == 4'd0, "R6 return at zero ignored", pending, 0);

    // R7: window of two
    cfg[7:4] = 4'd2;
    send(2'd0, 2'd0, 1'b0, 1'b1, "R2", 1'b0, e);
    send(2'd1, 2'd3, 1'b0, 1'b1, "R4", 1'b0, e);
    repeat (6 + HOLD) hi();
    check(xfer_ready == 1'b0, "R7 ready low at window", xfer_ready, 0);
    check(pending == 4'd2, "R7 pending at window", pending, 2);
    lo();
    valid = 1'b1;
    #1;
    check(stall == 1'b1, "R7 stall asserted", stall, 1);
    valid = 1'b0;
    ret_pulse();
    check(pending == 4'd1, "R7 pending after one return", pending, 1);
    check(xfer_ready == 1'b1, "R7 ready reopens", xfer_ready, 1);
    ret_pulse();

    // R8: asynchronous interlock
    cfg[7:4] = 4'd0;
    send(2'd1, 2'd1, 1'b0, 1'b0, "R8", 1'b0, e);
    repeat (3) hi();
    check(out_strobe == 1'b1, "R8 strobe high", out_strobe, 1);
    check(xfer_ready == 1'b0, "R8 ready low while waiting", xfer_ready, 0);
    repeat (3) hi();
    check(out_strobe == 1'b1, "R8 strobe held without return", out_strobe, 1);
    lo();
    ret = 1'b1;
    @(posedge clk);
    #1;
    x = hidx;
    exp_r.push_back(e + 3);
    exp_f.push_back(x + 2 + thr(2'd1, 1'b0));
    exp_t.push_back("R8");
    check(pending == 4'd0, "R8 pending cleared by return", pending, 0);
    repeat (4) hi();
    check(out_strobe == 1'b0, "R8 strobe dropped", out_strobe, 0);
    check(xfer_ready == 1'b0, "R8 ready low while return high", xfer_ready, 0);
    lo();
    ret = 1'b0;
    hi();
    check(xfer_ready == 1'b1, "R8 ready after return low", xfer_ready, 1);

    check(exp_r.size() == 0, "R3 all pulses seen", exp_r.size(), 0);

    // R1: reset cancels a delayed rising edge
    mon_en = 1'b0;
    cfg[7:4] = 4'hF;
    send(2'd3, 2'd3, 1'b1, 1'b0, "R1", 1'b0, e);
    rst = 1'b1;
    begin : quiet_a
      int hits;
      hits = 0;
      repeat (8) begin
        @(posedge clk or negedge clk);
        #1;
        if (out_strobe !== 1'b0) hits++;
      end
      check(hits == 0, "R1 delayed edge cancelled", hits, 0);
    end
    check(pending == 4'd0, "R1 pending cleared", pending, 0);
    lo();
    rst = 1'b0;

    // R1: reset while the strobe is high
    send(2'd0, 2'd0, 1'b0, 1'b0, "R1", 1'b0, e);
    hi();
    check(out_strobe == 1'b1, "R1 strobe high before reset", out_strobe, 1);
    rst = 1'b1;
    hi();
    begin : quiet_b
      int hits;
      hits = 0;
      repeat (8) begin
        @(posedge clk or negedge clk);
        #1;
        if (out_strobe !== 1'b0) hits++;
      end
      check(hits == 0, "R1 strobe forced low", hits, 0);
    end
    lo();
    rst = 1'b0;
    hi();
    check(xfer_ready == 1'b1, "R1 ready after release", xfer_ready, 1);
    check(pending == 4'd0, "R1 pending zero after release", pending, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule